// File: doc/BRIEF.md
# Two-Operand Arc-Tangent Special-Case and Quadrant Front End

This block sits ahead of the divider and the core evaluator in a single-precision two-operand arc-tangent unit. It accepts a pair of binary32 operands, `y` and `x`, through a valid/ready handshake. It sorts each pair into one of two paths.

The first path covers operand pairs with a NaN, an infinity or a zero. For these pairs the final binary32 answer is fully determined by the operand classes, so the block returns it directly with the bypass flag set.

The second path covers finite, nonzero pairs. For these the block emits a descriptor for the downstream core:
- a numerator and a denominator, ordered so that the magnitude of their ratio never exceeds one;
- an additive offset of 0, π/2 or π, with a sign for that offset;
- a flag that tells the core to negate its own result.

The core evaluates `a = atan(|num|/|den|)`, which lies in 0..π/4. The final answer is then `(ofs_neg ? -1 : +1) * offset + (core_neg ? -a : +a)`. The core result is bounded, so this final addition never cancels significant bits.

The stage is a single registered stage with one cycle of latency. It holds its output while the downstream side is not ready.

Top module: `atan2_front`

## Requirements
- R1: If x is NaN, the result is the x pattern unchanged. Otherwise, if y is NaN, the result is the y pattern. Either case sets the bypass flag, and a NaN in x outranks every other rule.
- R2: With x = +∞, the bypass result is π/4 (0x3F490FDB) carrying y's sign when |y| = ∞, and a zero carrying y's sign when y is finite.
- R3: With x = −∞, the bypass result is 3π/4 (0x4016CBE4) carrying y's sign when |y| = ∞, and π (0x40490FDB) carrying y's sign when y is finite.
- R4: With |y| = ∞ and x finite (including zero), the bypass result is π/2 (0x3FC90FDB) carrying y's sign.
- R5: With x = ±0 and y finite and nonzero, the bypass result is π/2 carrying y's sign. Denormal operands count as nonzero.
- R6: With y = ±0 and x not NaN or infinite, the bypass result is a zero carrying y's sign when x's sign bit is 0, and π carrying y's sign when x's sign bit is 1.
- R7: For finite nonzero pairs, the block compares magnitudes as unsigned integers over bits 30:0.
  - If |y| > |x|, it sets swap = 1, num = x and den = y.
  - Otherwise (ties included), it sets swap = 0, num = y and den = x.
  - The operands are passed through with their sign bits, and the bypass flag is 0.
- R8: For finite nonzero pairs, the offset select is coded 0 = zero, 1 = π/2, 2 = π.
  - The select is 0 when x > 0 without swap, 1 whenever swap is set, and 2 when x < 0 without swap.
  - The offset sign equals y's sign.
  - core_neg = sign(y) XOR swap XOR sign(x).
  - The reconstruction formula then equals atan2(y, x) in all four quadrants.
- R9: When bypass is 1, the fields swap, offset select, offset sign, core_neg, num and den are all zero. When bypass is 0, the result field is zero.
- R10: The output appears one clock edge after an accepted input. While out_valid is high and out_ready is low, in_ready is low and every output holds steady. A new operand can be accepted on the same edge that drains the held one.
- R11: During and after an active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Stage can take a pair this cycle |
| in_y | input | 32 | Binary32 y operand |
| in_x | input | 32 | Binary32 x operand |
| out_valid | output | 1 | Output fields valid |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_bypass | output | 1 | Result is final; core not needed |
| out_result | output | 32 | Final binary32 result when bypassing |
| out_swap | output | 1 | Numerator and denominator were exchanged |
| out_num | output | 32 | Numerator operand for the core |
| out_den | output | 32 | Denominator operand for the core |
| out_ofs_sel | output | 2 | Offset: 0 zero, 1 π/2, 2 π |
| out_ofs_neg | output | 1 | Offset is subtracted |
| out_core_neg | output | 1 | Core result is negated |

## Verification
Two actions can fall on the same clock edge: draining a held output and capturing the next operand pair. The bench provokes this by parking a result behind a low out_ready while a second pair waits on the input. It then raises out_ready and checks two things. First, the held fields stayed unchanged through the stall. Second, the very next sample shows the second pair's descriptor with no gap cycle. A second overlap is judged across the whole operand sweep: the special-case ladder and the magnitude ordering both act on the same cycle's pair. The bench checks that a special pair always wins and leaves the descriptor cleared. For random finite pairs, it rebuilds the final angle from the descriptor and compares it with a real-valued two-argument arc tangent.

// File: rtl/atan2_front.sv
module atan2_front #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter logic [31:0] K_PI_4  = 32'h3F490FDB,
  parameter logic [31:0] K_PI_2  = 32'h3FC90FDB,
  parameter logic [31:0] K_3PI_4 = 32'h4016CBE4,
  parameter logic [31:0] K_PI    = 32'h40490FDB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_y,
  input  logic [31:0] in_x,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_bypass,
  output logic [31:0] out_result,
  output logic        out_swap,
  output logic [31:0] out_num,
  output logic [31:0] out_den,
  output logic [1:0]  out_ofs_sel,
  output logic        out_ofs_neg,
  output logic        out_core_neg
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int MW = W - 1;

  logic sy, sx;
  logic y_emax, x_emax, y_mnz, x_mnz;
  logic y_nan, x_nan, y_inf, x_inf, y_zero, x_zero;
  logic y_bigger;

  assign sy       = in_y[W-1];
  assign sx       = in_x[W-1];
  assign y_emax   = &in_y[W-2:MAN_W];
  assign x_emax   = &in_x[W-2:MAN_W];
  assign y_mnz    = |in_y[MAN_W-1:0];
  assign x_mnz    = |in_x[MAN_W-1:0];
  assign y_nan    = y_emax & y_mnz;
  assign x_nan    = x_emax & x_mnz;
  assign y_inf    = y_emax & ~y_mnz;
  assign x_inf    = x_emax & ~x_mnz;
  assign y_zero   = ~|in_y[W-2:0];
  assign x_zero   = ~|in_x[W-2:0];
  assign y_bigger = in_y[MW-1:0] > in_x[MW-1:0];

  logic        n_byp, n_swap, n_ofsn, n_coren;
  logic [W-1:0] n_res, n_num, n_den;
  logic [1:0]  n_sel;

  always_comb begin
    n_byp   = 1'b1;
    n_res   = '0;
    n_swap  = 1'b0;
    n_num   = '0;
    n_den   = '0;
    n_sel   = 2'd0;
    n_ofsn  = 1'b0;
    n_coren = 1'b0;
    if (x_nan)                 n_res = in_x;
    else if (y_nan)            n_res = in_y;
    else if (x_inf && !sx)     n_res = y_inf ? {sy, K_PI_4[W-2:0]} : {sy, {(W-1){1'b0}}};
    else if (x_inf)            n_res = y_inf ? {sy, K_3PI_4[W-2:0]} : {sy, K_PI[W-2:0]};
    else if (y_inf)            n_res = {sy, K_PI_2[W-2:0]};
    else if (x_zero && !y_zero) n_res = {sy, K_PI_2[W-2:0]};
    else if (y_zero)           n_res = sx ? {sy, K_PI[W-2:0]} : {sy, {(W-1){1'b0}}};
    else begin
      n_byp   = 1'b0;
      n_swap  = y_bigger;
      n_num   = y_bigger ? in_x : in_y;
      n_den   = y_bigger ? in_y : in_x;
      n_sel   = y_bigger ? 2'd1 : (sx ? 2'd2 : 2'd0);
      n_ofsn  = sy;
      n_coren = sy ^ y_bigger ^ sx;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_bypass   <= 1'b0;
      out_result   <= '0;
      out_swap     <= 1'b0;
      out_num      <= '0;
      out_den      <= '0;
      out_ofs_sel  <= 2'd0;
      out_ofs_neg  <= 1'b0;
      out_core_neg <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bypass   <= n_byp;
        out_result   <= n_res;
        out_swap     <= n_swap;
        out_num      <= n_num;
        out_den      <= n_den;
        out_ofs_sel  <= n_sel;
        out_ofs_neg  <= n_ofsn;
        out_core_neg <= n_coren;
      end
    end
  end
endmodule

// File: rtl/atan2_front_chk.sv
module atan2_front_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_bypass,
  input logic [W-1:0] out_result,
  input logic         out_swap,
  input logic [W-1:0] out_num,
  input logic [W-1:0] out_den,
  input logic [1:0]   out_ofs_sel,
  input logic         out_ofs_neg,
  input logic         out_core_neg
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_num)
      && $stable(out_den) && $stable(out_bypass) && $stable(out_ofs_sel)
      && $stable(out_core_neg));

  assert_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bypass |-> out_num[W-2:0] <= out_den[W-2:0]);

  assert_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bypass |-> out_ofs_sel != 2'd3 && !(out_ofs_sel == 2'd2 && out_swap));

  assert_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bypass |->
      out_core_neg == (out_ofs_neg ^ out_swap ^ (out_swap ? out_num[W-1] : out_den[W-1])));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bypass |-> !out_swap && out_ofs_sel == 2'd0 && !out_ofs_neg
      && !out_core_neg && out_num == '0 && out_den == '0);
endmodule

bind atan2_front atan2_front_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_bypass(out_bypass), .out_result(out_result),
  .out_swap(out_swap), .out_num(out_num), .out_den(out_den),
  .out_ofs_sel(out_ofs_sel), .out_ofs_neg(out_ofs_neg), .out_core_neg(out_core_neg)
);

// File: tb/atan2_front_bench.sv
`timescale 1ns/1ps
module atan2_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_y = '0, in_x = '0;
  logic in_ready, out_valid, out_bypass, out_swap, out_ofs_neg, out_core_neg;
  logic [31:0] out_result, out_num, out_den;
  logic [1:0] out_ofs_sel;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  atan2_front u_atan2_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready),
    .out_bypass(out_bypass), .out_result(out_result), .out_swap(out_swap),
    .out_num(out_num), .out_den(out_den), .out_ofs_sel(out_ofs_sel),
    .out_ofs_neg(out_ofs_neg), .out_core_neg(out_core_neg));

  localparam int NV = 33;
  // {y, x, bypass, result, swap, sel, ofs_neg, core_neg}
  localparam logic [101:0] VEC [NV] = '{
    {32'h3F800000, 32'h7FC00001, 1'b1, 32'h7FC00001, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h7FC00002, 32'h7FC00001, 1'b1, 32'h7FC00001, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h7FC00002, 32'h3F800000, 1'b1, 32'h7FC00002, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h7FC00002, 32'h7F800000, 1'b1, 32'h7FC00002, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h7F800000, 32'h7F800000, 1'b1, 32'h3F490FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hFF800000, 32'h7F800000, 1'b1, 32'hBF490FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h3F800000, 32'h7F800000, 1'b1, 32'h00000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hBF800000, 32'h7F800000, 1'b1, 32'h80000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h7F800000, 32'hFF800000, 1'b1, 32'h4016CBE4, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hFF800000, 32'hFF800000, 1'b1, 32'hC016CBE4, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h40000000, 32'hFF800000, 1'b1, 32'h40490FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h80000000, 32'hFF800000, 1'b1, 32'hC0490FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h7F800000, 32'h3F800000, 1'b1, 32'h3FC90FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hFF800000, 32'h80000000, 1'b1, 32'hBFC90FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h3F800000, 32'h00000000, 1'b1, 32'h3FC90FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hC0000000, 32'h80000000, 1'b1, 32'hBFC90FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h00000001, 32'h00000000, 1'b1, 32'h3FC90FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h00000000, 32'h40000000, 1'b1, 32'h00000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h00000000, 32'h80000000, 1'b1, 32'h40490FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h80000000, 32'hBF800000, 1'b1, 32'hC0490FDB, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h3F800000, 32'h40000000, 1'b0, 32'h00000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hBF800000, 32'h40000000, 1'b0, 32'h00000000, 1'b0, 2'd0, 1'b1, 1'b1},
    {32'h40000000, 32'h3F800000, 1'b0, 32'h00000000, 1'b1, 2'd1, 1'b0, 1'b1},
    {32'hC0000000, 32'h3F800000, 1'b0, 32'h00000000, 1'b1, 2'd1, 1'b1, 1'b0},
    {32'h3F800000, 32'hC0000000, 1'b0, 32'h00000000, 1'b0, 2'd2, 1'b0, 1'b1},
    {32'hBF800000, 32'hC0000000, 1'b0, 32'h00000000, 1'b0, 2'd2, 1'b1, 1'b0},
    {32'h40000000, 32'hBF800000, 1'b0, 32'h00000000, 1'b1, 2'd1, 1'b0, 1'b0},
    {32'hC0000000, 32'hBF800000, 1'b0, 32'h00000000, 1'b1, 2'd1, 1'b1, 1'b1},
    {32'h3F800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'hBF800000, 32'hBF800000, 1'b0, 32'h00000000, 1'b0, 2'd2, 1'b1, 1'b0},
    {32'h00000001, 32'h00000002, 1'b0, 32'h00000000, 1'b0, 2'd0, 1'b0, 1'b0},
    {32'h00000003, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 2'd1, 1'b0, 1'b1}
  };

  function automatic string tag_of(input int i);
    if (i < 4)  return "R1";
    if (i < 8)  return "R2";
    if (i < 12) return "R3";
    if (i < 14) return "R4";
    if (i < 17) return "R5";
    if (i < 21) return "R6";
    return "R7,R8";
  endfunction

  function automatic real f2r(input logic [31:0] b);
    real m;
    int e;
    e = int'(b[30:23]);
    m = real'(b[22:0]);
    if (e == 0) m = m * (2.0 ** (-149));
    else        m = (m + 8388608.0) * (2.0 ** (e - 150));
    return b[31] ? -m : m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [101:0] act, input logic [101:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] y, input logic [31:0] x);
    @(negedge clk);
    in_y = y; in_x = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] exp_f, act_f;
      logic [63:0] exp_nd;
      send(VEC[i][101:70], VEC[i][69:38]);
      exp_f = VEC[i][37:0];
      act_f = {out_bypass, out_result, out_swap, out_ofs_sel, out_ofs_neg, out_core_neg};
      check(out_valid && act_f == exp_f, tag_of(i), {63'd0, out_valid, act_f}, {64'd1, exp_f});
      if (exp_f[37])
        exp_nd = 64'd0;  // R9 descriptor cleared on bypass
      else
        exp_nd = exp_f[4] ? {VEC[i][69:38], VEC[i][101:70]} : {VEC[i][101:70], VEC[i][69:38]};
      check({out_num, out_den} == exp_nd, exp_f[37] ? "R9" : "R7", {38'd0, out_num, out_den}, {38'd0, exp_nd});
    end

    for (int k = 0; k < 300; k++) begin
      logic [31:0] ry, rx;
      real yr, xr, ref_a, rec, off;
      ry = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
      rx = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
      if (k % 7 == 0) rx[30:23] = ry[30:23];
      send(ry, rx);
      yr = f2r(ry); xr = f2r(rx);
      ref_a = $atan2(yr, xr);
      off = (out_ofs_sel == 2'd1) ? 1.5707963267948966 : (out_ofs_sel == 2'd2) ? 3.141592653589793 : 0.0;
      rec = $atan((f2r(out_num) < 0.0 ? -f2r(out_num) : f2r(out_num)) /
                  (f2r(out_den) < 0.0 ? -f2r(out_den) : f2r(out_den)));
      rec = (out_ofs_neg ? -off : off) + (out_core_neg ? -rec : rec);
      check(!out_bypass && out_num[30:0] <= out_den[30:0], "R7",
            {37'd0, out_bypass, out_num, out_den}, {38'd0, out_den, out_den});
      check((rec - ref_a) < 1.0e-9 && (ref_a - rec) < 1.0e-9, "R8",
            {38'd0, $realtobits(rec)}, {38'd0, $realtobits(ref_a)});
    end

    // R10: stall hold, then drain and accept on the same edge
    @(negedge clk);
    out_ready = 1'b0;
    in_y = 32'h40000000; in_x = 32'h3F800000; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && !in_ready, "R10", {out_valid, in_ready}, 2'b10);
    in_y = 32'hBF800000; in_x = 32'hC0000000;
    repeat (3) @(negedge clk);
    check(out_valid && !in_ready && out_swap && out_ofs_sel == 2'd1 && out_num == 32'h3F800000,
          "R10", {out_swap, out_ofs_sel, out_num}, {1'b1, 2'd1, 32'h3F800000});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && !out_swap && out_ofs_sel == 2'd2 && out_num == 32'hBF800000,
          "R10", {out_valid, out_swap, out_ofs_sel, out_num}, {1'b1, 1'b0, 2'd2, 32'hBF800000});
    @(negedge clk);
    check(!out_valid, "R10", out_valid, 1'b0);

    // R11: reset while a result is held
    out_ready = 1'b0;
    send(32'h3F800000, 32'h40000000);
    check(out_valid, "R10", out_valid, 1'b1);
    rst_n = 1'b0;
    #1;
    check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R11", out_valid, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule